// File: doc/BRIEF.md
# Real-Time-Clock Alarm and Interrupt Flag Unit

This block sits beside the timekeeping counters of a real-time clock. After each one-second update it checks three alarm bytes (seconds, minutes, hours) against the current time. It also keeps the interrupt flag byte, which holds three event flags: update-ended, alarm match and periodic tick. A level interrupt request is raised when a flag whose enable is set in the control byte becomes active.

The host reaches the block through a small register port. It can write and read the three alarm bytes and the control byte, and it can read the flag byte. Reading the flag byte returns its value and clears it in the same cycle. An alarm byte with both of its top bits set acts as a wildcard and matches any value of its field. While the halt bit of the control byte is set, update strobes produce no flags. The timekeeping counters themselves are outside this block; their bytes arrive on inputs.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The alarm bytes are written and read at addresses 0x01 (seconds), 0x03 (minutes) and 0x05 (hours). The control byte is at 0x0B and the flag byte at 0x0C. Read data appears on `host_rdata` one cycle after `host_rd`. Reads of any other address return 0x00.
- R2: An alarm byte whose bits 7 and 6 are both 1 (0xC0 to 0xFF) matches any value of its field. Any other alarm byte, including 0x80 and 0xBF, matches only an identical time byte.
- R3: On an `upd_done` strobe with halt clear, flag byte bit 4 (update ended) is set. Bit 5 (alarm) is also set when all three alarm fields match the current time bytes.
- R4: Every `per_tick` strobe sets flag byte bit 6 (periodic), whether or not its interrupt is enabled and whether or not halt is set.
- R5: Flag byte bit 7 is set when (bit 4 and UIE) or (bit 5 and AIE) or (bit 6 and PIE) holds. The enables are control byte bits 4 (UIE), 5 (AIE) and 6 (PIE). Bit 7 stays set until the flag byte is cleared. It is also raised one cycle after an enable is written while its flag is already pending.
- R6: A read of the flag byte returns the value it held before the read, and then the whole flag byte is cleared. A tick or update strobe in the same cycle as that read is not lost: its flag appears in the cleared byte.
- R7: `irq` is level-high and equals flag byte bit 7. It falls in the cycle after the read that clears the flag byte.
- R8: While control byte bit 7 (halt) is set, `upd_done` sets neither the update-ended flag nor the alarm flag.
- R9: Synchronous reset clears control byte bits 6 to 3 (PIE, AIE, UIE, square-wave enable), the whole flag byte and `irq`. Control bits 7 and 2 to 0 and the alarm bytes keep their values.
- R10: Host writes to the flag byte address have no effect on the flag byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 7 | Register index for host read or write |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Registered read data, valid the cycle after `host_rd` |
| upd_done | input | 1 | One-cycle strobe: the time update has completed |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte, including its PM bit |
| per_tick | input | 1 | One-cycle periodic event strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 7-bit register index and three 8-bit alarm fields. At this size every address it decodes can be reached, as can the wildcard boundary between 0xBF and 0xC0 and the exact-match case for 0x80 in an alarm byte. The bench also covers each enable on its own, the late enabling of a pending flag, and a tick that coincides with the clearing read. The full field width lets the hours byte be compared with its PM bit, so a match that differs only in bit 7 is exercised.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int BYTE_W = 8;

  // register indices that the host port decodes
  localparam logic [6:0] IDX_ALM_SEC  = 7'h01;
  localparam logic [6:0] IDX_ALM_MIN  = 7'h03;
  localparam logic [6:0] IDX_ALM_HOUR = 7'h05;
  localparam logic [6:0] IDX_CTRL     = 7'h0B;
  localparam logic [6:0] IDX_FLAGS    = 7'h0C;

  // control byte bit positions
  localparam int CTL_HALT = 7;
  localparam int CTL_PIE  = 6;
  localparam int CTL_AIE  = 5;
  localparam int CTL_UIE  = 4;
  localparam int CTL_SQW  = 3;

  // event flag vector: index 0 update, 1 alarm, 2 periodic
  localparam int EV_N   = 3;
  localparam int EV_UPD = 0;
  localparam int EV_ALM = 1;
  localparam int EV_PER = 2;
  localparam int EV_LSB = 4; // flag byte bit of event 0

  typedef logic [EV_N-1:0] ev_vec_t;
endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
  parameter int FIELD_W = 8
) (
  input  logic [FIELD_W-1:0] alarm_val,
  input  logic [FIELD_W-1:0] time_val,
  output logic               hit
);
  localparam int TOP = FIELD_W - 1;

  logic wild;
  always_comb begin
    wild = alarm_val[TOP] & alarm_val[TOP-1];
    hit  = wild | (alarm_val == time_val);
  end
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher #(
  parameter int NUM_FIELDS = 3,
  parameter int FIELD_W    = 8
) (
  input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_vec,
  input  logic [NUM_FIELDS*FIELD_W-1:0] time_vec,
  output logic                          all_hit
);
  logic [NUM_FIELDS-1:0] hit_vec;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    alarm_field_match #(.FIELD_W(FIELD_W)) u_match (
      .alarm_val(alarm_vec[g*FIELD_W +: FIELD_W]),
      .time_val (time_vec[g*FIELD_W +: FIELD_W]),
      .hit      (hit_vec[g])
    );
  end

  assign all_hit = &hit_vec;
endmodule

// File: rtl/host_regs.sv
module host_regs
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int NUM_FIELDS = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic                         wr_en,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [NUM_FIELDS*BYTE_W-1:0] alarm_vec,
  output logic [BYTE_W-1:0]            ctrl
);
  localparam logic [BYTE_W-1:0] RST_CLR =
    BYTE_W'((1 << CTL_PIE) | (1 << CTL_AIE) | (1 << CTL_UIE) | (1 << CTL_SQW));

  logic [BYTE_W-1:0] alarm_q [NUM_FIELDS] = '{default: '0};
  logic [BYTE_W-1:0] ctrl_q = '0;

  // alarm field g sits at index 2*g+1
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_alarm
    localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(2 * g + 1);
    always_ff @(posedge clk) begin
      if (wr_en && wr_addr == MY_IDX) alarm_q[g] <= wr_data;
    end
    assign alarm_vec[g*BYTE_W +: BYTE_W] = alarm_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= ctrl_q & ~RST_CLR;
    else if (wr_en && wr_addr == ADDR_W'(IDX_CTRL)) ctrl_q <= wr_data;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/flag_core.sv
module flag_core
  import rtc_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  logic    upd_done,
  input  logic    halt,
  input  logic    alarm_hit,
  input  logic    per_tick,
  input  ev_vec_t enables,
  output ev_vec_t flags,
  output logic    irqf
);
  ev_vec_t flags_q, flags_n;
  logic    irqf_q, irqf_n;

  always_comb begin
    flags_n = clr ? '0 : flags_q;
    if (per_tick) flags_n[EV_PER] = 1'b1;
    if (upd_done && !halt) begin
      flags_n[EV_UPD] = 1'b1;
      if (alarm_hit) flags_n[EV_ALM] = 1'b1;
    end
    irqf_n = (clr ? 1'b0 : irqf_q) | (|(flags_n & enables));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irqf_q  <= 1'b0;
    end else begin
      flags_q <= flags_n;
      irqf_q  <= irqf_n;
    end
  end

  assign flags = flags_q;
  assign irqf  = irqf_q;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int NUM_FIELDS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  output logic [7:0]        host_rdata,
  input  logic              upd_done,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic              per_tick,
  output logic              irq
);
  localparam int VEC_W = NUM_FIELDS * BYTE_W;

  logic [VEC_W-1:0]  alarm_vec;
  logic [VEC_W-1:0]  time_vec;
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] flag_byte;
  logic [BYTE_W-1:0] rdata_q;
  ev_vec_t           flags_q;
  ev_vec_t           en_vec;
  logic              irqf_q;
  logic              all_hit;
  logic              rd_flags;

  assign time_vec = VEC_W'({cur_hour, cur_min, cur_sec});

  host_regs #(.ADDR_W(ADDR_W), .NUM_FIELDS(NUM_FIELDS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_addr  (host_addr),
    .wr_en    (host_wr),
    .wr_data  (host_wdata),
    .alarm_vec(alarm_vec),
    .ctrl     (ctrl_q)
  );

  alarm_matcher #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(BYTE_W)) u_match (
    .alarm_vec(alarm_vec),
    .time_vec (time_vec),
    .all_hit  (all_hit)
  );

  assign en_vec   = ctrl_q[CTL_UIE +: EV_N];
  assign rd_flags = host_rd && (host_addr == ADDR_W'(IDX_FLAGS));

  flag_core u_flags (
    .clk      (clk),
    .rst      (rst),
    .clr      (rd_flags),
    .upd_done (upd_done),
    .halt     (ctrl_q[CTL_HALT]),
    .alarm_hit(all_hit),
    .per_tick (per_tick),
    .enables  (en_vec),
    .flags    (flags_q),
    .irqf     (irqf_q)
  );

  always_comb begin
    flag_byte = '0;
    flag_byte[BYTE_W-1] = irqf_q;
    flag_byte[EV_LSB +: EV_N] = flags_q;
  end

  // registered read mux
  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (host_rd) begin
      rdata_q <= '0;
      if (host_addr == ADDR_W'(IDX_CTRL))       rdata_q <= ctrl_q;
      else if (host_addr == ADDR_W'(IDX_FLAGS)) rdata_q <= flag_byte;
      else begin
        for (int g = 0; g < NUM_FIELDS; g++) begin
          if (host_addr == ADDR_W'(2 * g + 1)) rdata_q <= alarm_vec[g*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  assign host_rdata = rdata_q;
  assign irq        = irqf_q;
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic [7:0]        host_rdata,
  input logic              upd_done,
  input logic              per_tick,
  input logic              irq,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        flag_byte
);
  logic rd_f;
  assign rd_f = host_rd && (host_addr == ADDR_W'(IDX_FLAGS));

  // R6: flag read returns the pre-read value
  a_r6_read_value: assert property (@(posedge clk) disable iff (rst)
    rd_f |=> host_rdata == $past(flag_byte));

  // R7: quiet read clears everything and drops irq
  a_r7_irq_falls: assert property (@(posedge clk) disable iff (rst)
    (rd_f && !per_tick && !upd_done) |=> (!irq && flag_byte == 8'h00));

  // R3: unhalted update sets the update-ended flag
  a_r3_update_flag: assert property (@(posedge clk) disable iff (rst)
    (upd_done && !ctrl_q[CTL_HALT]) |=> flag_byte[4]);

  // R4: tick always sets the periodic flag
  a_r4_tick_flag: assert property (@(posedge clk) disable iff (rst)
    per_tick |=> flag_byte[6]);

  // R8: halt keeps a clear update flag clear
  a_r8_halt_blocks: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CTL_HALT] && !flag_byte[4]) |=> !flag_byte[4]);

  // R5: an interrupt always has an event flag behind it
  a_r5_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_byte[6:4] != 3'b000));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_addr (host_addr),
  .host_rd   (host_rd),
  .host_rdata(host_rdata),
  .upd_done  (upd_done),
  .per_tick  (per_tick),
  .irq       (irq),
  .ctrl_q    (ctrl_q),
  .flag_byte (flag_byte)
);

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       upd_done = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
  logic       per_tick = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_pend = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  rtc_alarm_irq u_rtc_alarm_irq (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .upd_done(upd_done), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .per_tick(per_tick), .irq(irq)
  );

  always @(posedge clk) rd_pend <= host_rd;

  // monitor: pops an expected read result for every issued read
  always @(negedge clk) begin
    if (rd_pend) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read data %02h expected none", host_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (host_rdata !== e) begin
          errors++;
          $display("FAIL %s: read data %02h expected %02h", t, host_rdata, e);
        end
      end
    end
  end

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq %0b expected %0b", t, irq, e);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic upd(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    @(negedge clk);
    cur_hour = h; cur_min = m; cur_sec = s; upd_done = 1'b1;
    @(negedge clk);
    upd_done = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    per_tick = 1'b1;
    @(negedge clk);
    per_tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk_irq(1'b0, "R9 reset irq");
    rd(7'h0C, 8'h00, "R9 reset flags");
    rd(7'h0B, 8'h00, "R9 reset ctrl");

    // R1 alarm registers
    wr(7'h01, 8'h30); wr(7'h03, 8'h15); wr(7'h05, 8'h08);
    rd(7'h01, 8'h30, "R1 alarm sec");
    rd(7'h03, 8'h15, "R1 alarm min");
    rd(7'h05, 8'h08, "R1 alarm hour");
    rd(7'h02, 8'h00, "R1 unmapped index");

    // R3 match and non-match
    upd(8'h08, 8'h15, 8'h30);
    rd(7'h0C, 8'h30, "R3 alarm match");
    chk_irq(1'b0, "R5 no enables");
    rd(7'h0C, 8'h00, "R6 cleared after read");
    upd(8'h08, 8'h15, 8'h31);
    rd(7'h0C, 8'h10, "R3 update only");
    upd(8'h88, 8'h15, 8'h30);
    rd(7'h0C, 8'h10, "R3 PM bit differs");

    // R2 wildcards and boundary
    wr(7'h01, 8'hC0); wr(7'h03, 8'hFF);
    upd(8'h08, 8'h42, 8'h07);
    rd(7'h0C, 8'h30, "R2 wildcard sec and min");
    upd(8'h09, 8'h42, 8'h07);
    rd(7'h0C, 8'h10, "R2 hour still exact");
    wr(7'h01, 8'hBF); wr(7'h03, 8'h80);
    upd(8'h08, 8'h80, 8'h3F);
    rd(7'h0C, 8'h10, "R2 0xBF not wildcard");
    upd(8'h08, 8'h80, 8'hBF);
    rd(7'h0C, 8'h30, "R2 0x80 exact match");
    upd(8'h08, 8'h00, 8'hBF);
    rd(7'h0C, 8'h10, "R2 0x80 not wildcard");

    // R4 periodic without enable
    tick();
    chk_irq(1'b0, "R4 tick no PIE");
    rd(7'h0C, 8'h40, "R4 periodic flag");

    // R5/R7 PIE
    wr(7'h0B, 8'h40);
    tick();
    chk_irq(1'b1, "R7 irq with PIE");
    rd(7'h0C, 8'hC0, "R5 periodic irq");
    chk_irq(1'b0, "R7 irq falls after read");

    // R5 UIE
    wr(7'h0B, 8'h10);
    upd(8'h01, 8'h01, 8'h01);
    chk_irq(1'b1, "R5 UIE irq");
    rd(7'h0C, 8'h90, "R5 update irq");
    // R5 AIE
    wr(7'h0B, 8'h20);
    upd(8'h01, 8'h01, 8'h01);
    chk_irq(1'b0, "R5 AIE no match");
    rd(7'h0C, 8'h10, "R5 AIE mismatch flags");
    upd(8'h08, 8'h80, 8'hBF);
    rd(7'h0C, 8'hB0, "R5 alarm irq");

    // R5 late enable of pending flag
    wr(7'h0B, 8'h00);
    upd(8'h01, 8'h01, 8'h01);
    chk_irq(1'b0, "R5 pending no enable");
    wr(7'h0B, 8'h10);
    @(negedge clk);
    chk_irq(1'b1, "R5 late enable raises irq");
    rd(7'h0C, 8'h90, "R5 late enable flags");

    // R10 write to flag byte ignored
    wr(7'h0B, 8'h00);
    wr(7'h0C, 8'hFF);
    chk_irq(1'b0, "R10 write ignored irq");
    rd(7'h0C, 8'h00, "R10 write ignored flags");

    // R8 halt
    wr(7'h0B, 8'h90);
    upd(8'h08, 8'h80, 8'hBF);
    chk_irq(1'b0, "R8 halt no irq");
    rd(7'h0C, 8'h00, "R8 halt no flags");
    tick();
    rd(7'h0C, 8'h40, "R4 tick during halt");

    // R6 tick in same cycle as clearing read
    wr(7'h0B, 8'h00);
    upd(8'h01, 8'h01, 8'h01);
    @(negedge clk);
    host_addr = 7'h0C; host_rd = 1'b1; per_tick = 1'b1;
    exp_q.push_back(8'h10); tag_q.push_back("R6 read with coincident tick");
    @(negedge clk);
    host_rd = 1'b0; per_tick = 1'b0;
    rd(7'h0C, 8'h40, "R6 coincident tick kept");

    // R9 reset keeps halt, low bits and alarms
    wr(7'h0B, 8'hFF);
    tick();
    chk_irq(1'b1, "R9 irq before reset");
    do_reset();
    chk_irq(1'b0, "R9 irq after reset");
    rd(7'h0B, 8'h87, "R9 ctrl partial clear");
    rd(7'h0C, 8'h00, "R9 flags after reset");
    rd(7'h05, 8'h08, "R9 alarm kept");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads outstanding expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule